// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two binary floating-point operands and reports how they relate. It returns a condition code with exactly one bit set (less, greater, equal or unordered) and two exception flags. One flag reports a signalling NaN operand. The other reports an invalid compare, which only the ordered form of the compare can raise. Each operand is first sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. Sign and magnitude rules then set the code. Subnormal values are treated as ordinary finite numbers.

The caller presents both operands, chooses the ordered or unordered form, and states whether the invalid exception is enabled, all with a one-cycle request strobe. The registered result appears one clock later, marked by a one-cycle done pulse. It stays on the outputs until the next request. The exponent and fraction widths are parameters, and the default is the 64-bit double format.

Top module: `fpcmp_unit`

## Requirements
- R1: The condition code `cc` always has exactly one bit set. Bit 3 means A less than B, bit 2 greater, bit 1 equal and bit 0 unordered. A request sampled at a rising edge with `req_vld` high updates `cc` and both flags at that edge, and `rsp_vld` is high for exactly the following cycle. Back-to-back requests give back-to-back results.
- R2: Reset leaves `rsp_vld` low, `cc` at 4'b0010 and both flags low. While `req_vld` is low, changes on the operand and mode inputs have no effect, and `cc` and the flags hold their last values.
- R3: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. When either operand is a NaN, `cc` is 4'b0001.
- R4: A NaN whose fraction MSB (bit 51 in the default format) is 0 is signalling. If either operand is a signalling NaN, `flg_snan` is set, whether the ordered or the unordered form is selected.
- R5: When `ordered` is 1 and an operand is a NaN, `flg_inv_cmp` is set if `inv_en` is 1 or if either operand is a quiet NaN. With only signalling NaNs and `inv_en` at 0, it stays clear.
- R6: When `ordered` is 0, `flg_inv_cmp` is never set. Neither flag is set when no operand is a NaN.
- R7: Two zeros compare equal, whatever their signs.
- R8: When the signs differ and the operands are not both zero, the negative operand is the smaller one. The result is less when A is negative and greater when A is positive.
- R9: For non-NaN operands of the same sign, the order is set by magnitude. Infinity ranks above every finite value, and every finite value ranks above zero. When both operands are negative, the order is reversed.
- R10: Two infinities of the same sign compare equal. Two finite operands (normal or subnormal) with the same sign and the same bits also compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe: operands and mode are sampled this cycle |
| opnd_a | input | 64 | Operand A (sign, exponent, fraction) |
| opnd_b | input | 64 | Operand B |
| ordered | input | 1 | 1 selects the ordered compare, 0 the unordered compare |
| inv_en | input | 1 | Invalid-exception enable, used by the ordered compare |
| rsp_vld | output | 1 | One-cycle done pulse for each request |
| cc | output | 4 | One-hot code: [3] less, [2] greater, [1] equal, [0] unordered |
| flg_snan | output | 1 | A signalling-NaN operand was seen |
| flg_inv_cmp | output | 1 | Invalid ordered compare |

## Verification
The bench builds the unit with the default 11-bit exponent and 52-bit fraction. At that width the host's own double comparison can act as an independent reference for every non-NaN pair. This covers the subnormal boundary, the largest finite value against infinity, and signed zeros without any hand-built tables. Directed pairs target each NaN-flag rule under both modes and both enable values. A long run of mixed special and random operands, with idle gaps that toggle the unsampled inputs, then exercises the hold behaviour and back-to-back requests.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   // operand class
   typedef enum logic [2:0] {
      FK_ZERO   = 3'd0,
      FK_SUBN   = 3'd1,
      FK_NORM   = 3'd2,
      FK_INF    = 3'd3,
      FK_QNAN   = 3'd4,
      FK_SNAN   = 3'd5
   } fp_kind_e;

   // condition code, MSB first: less, greater, equal, unordered
   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic un;
   } fp_cc_t;

   localparam int CC_W = 4;

   localparam fp_cc_t CC_EQUAL = '{lt: 1'b0, gt: 1'b0, eq: 1'b1, un: 1'b0};

   function automatic logic kind_is_nan(input fp_kind_e k);
      return (k == FK_QNAN) || (k == FK_SNAN);
   endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W,
   localparam int MAG_W = OP_W - 1
) (
   input  logic [OP_W-1:0]  op,
   output fp_kind_e         kind,
   output logic             sign,
   output logic [MAG_W-1:0] mag
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              exp_nil;
   logic              frac_nil;

   assign sign     = op[OP_W-1];
   assign mag      = op[MAG_W-1:0];
   assign exp_f    = op[MAG_W-1 -: EXP_W];
   assign frac_f   = op[FRAC_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_nil  = ~|exp_f;
   assign frac_nil = ~|frac_f;

   always_comb begin
      if (exp_ones) begin
         if (frac_nil)
            kind = FK_INF;
         else if (frac_f[FRAC_W-1])
            kind = FK_QNAN;
         else
            kind = FK_SNAN;
      end else if (exp_nil) begin
         kind = frac_nil ? FK_ZERO : FK_SUBN;
      end else begin
         kind = FK_NORM;
      end
   end

endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
   import fpcmp_pkg::*;
#(
   parameter int MAG_W = 63
) (
   input  fp_kind_e         kind_a,
   input  fp_kind_e         kind_b,
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   input  logic             ordered,
   input  logic             inv_en,
   output fp_cc_t           cc,
   output logic             snan_hit,
   output logic             inv_cmp
);

   logic any_nan;
   logic any_snan;
   logic any_qnan;
   logic both_zero;
   logic a_smaller;

   assign any_nan   = kind_is_nan(kind_a) || kind_is_nan(kind_b);
   assign any_snan  = (kind_a == FK_SNAN) || (kind_b == FK_SNAN);
   assign any_qnan  = (kind_a == FK_QNAN) || (kind_b == FK_QNAN);
   assign both_zero = (kind_a == FK_ZERO) && (kind_b == FK_ZERO);
   assign a_smaller = mag_a < mag_b;

   always_comb begin
      cc       = '0;
      snan_hit = 1'b0;
      inv_cmp  = 1'b0;
      if (any_nan) begin
         cc.un    = 1'b1;
         snan_hit = any_snan;
         inv_cmp  = ordered && (inv_en || any_qnan);
      end else if (both_zero) begin
         cc.eq = 1'b1;
      end else if (sign_a != sign_b) begin
         cc.lt = sign_a;
         cc.gt = ~sign_a;
      end else if (mag_a == mag_b) begin
         cc.eq = 1'b1;
      end else if (a_smaller ^ sign_a) begin
         cc.lt = 1'b1;
      end else begin
         cc.gt = 1'b1;
      end
   end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W,
   localparam int MAG_W = OP_W - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_vld,
   input  logic [OP_W-1:0] opnd_a,
   input  logic [OP_W-1:0] opnd_b,
   input  logic            ordered,
   input  logic            inv_en,
   output logic            rsp_vld,
   output logic [CC_W-1:0] cc,
   output logic            flg_snan,
   output logic            flg_inv_cmp
);

   if (EXP_W < 2) begin : g_bad_exp
      $fatal(1, "fpcmp_unit: EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $fatal(1, "fpcmp_unit: FRAC_W must be at least 2");
   end

   logic [OP_W-1:0]  ops  [2];
   fp_kind_e         kind [2];
   logic             sgn  [2];
   logic [MAG_W-1:0] mag  [2];

   assign ops[0] = opnd_a;
   assign ops[1] = opnd_b;

   for (genvar gi = 0; gi < 2; gi++) begin : g_cls
      fpcmp_classify #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) cls_i (
         .op   (ops[gi]),
         .kind (kind[gi]),
         .sign (sgn[gi]),
         .mag  (mag[gi])
      );
   end

   fp_cc_t cc_d;
   logic   snan_d;
   logic   inv_d;

   fpcmp_decide #(
      .MAG_W (MAG_W)
   ) dec_i (
      .kind_a   (kind[0]),
      .kind_b   (kind[1]),
      .sign_a   (sgn[0]),
      .sign_b   (sgn[1]),
      .mag_a    (mag[0]),
      .mag_b    (mag[1]),
      .ordered  (ordered),
      .inv_en   (inv_en),
      .cc       (cc_d),
      .snan_hit (snan_d),
      .inv_cmp  (inv_d)
   );

   fp_cc_t cc_q;
   logic   snan_q;
   logic   inv_q;
   logic   vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         cc_q   <= CC_EQUAL;
         snan_q <= 1'b0;
         inv_q  <= 1'b0;
      end else begin
         vld_q <= req_vld;
         if (req_vld) begin
            cc_q   <= cc_d;
            snan_q <= snan_d;
            inv_q  <= inv_d;
         end
      end
   end

   assign rsp_vld     = vld_q;
   assign cc          = cc_q;
   assign flg_snan    = snan_q;
   assign flg_inv_cmp = inv_q;

endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_vld,
   input logic [OP_W-1:0] opnd_a,
   input logic [OP_W-1:0] opnd_b,
   input logic            ordered,
   input logic            rsp_vld,
   input logic [3:0]      cc,
   input logic            flg_snan,
   input logic            flg_inv_cmp
);

   logic a_zero, b_zero, a_inf;
   assign a_zero = ~|opnd_a[OP_W-2:0];
   assign b_zero = ~|opnd_b[OP_W-2:0];
   assign a_inf  = (&opnd_a[OP_W-2 -: EXP_W]) && ~|opnd_a[FRAC_W-1:0];

   // R1
   cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cc) == 1);

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);

   // R1
   rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> ($stable(cc) && $stable(flg_snan) && $stable(flg_inv_cmp)));

   // R4
   snan_means_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg_snan |-> cc[0]);

   // R5
   inv_means_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg_inv_cmp |-> cc[0]);

   // R6
   unord_form_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !ordered) |=> !flg_inv_cmp);

   // R7
   zeros_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && a_zero && b_zero) |=> (cc == 4'b0010));

   // R10
   same_inf_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && a_inf && (opnd_a == opnd_b)) |=> (cc == 4'b0010));

endmodule

bind fpcmp_unit fpcmp_unit_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_vld     (req_vld),
   .opnd_a      (opnd_a),
   .opnd_b      (opnd_b),
   .ordered     (ordered),
   .rsp_vld     (rsp_vld),
   .cc          (cc),
   .flg_snan    (flg_snan),
   .flg_inv_cmp (flg_inv_cmp)
);

// File: tb/fpcmp_unit_tb_top.sv
module fpcmp_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic        ordered = 1'b0;
   logic        inv_en = 1'b0;
   logic        rsp_vld;
   logic [3:0]  cc;
   logic        flg_snan;
   logic        flg_inv_cmp;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   fpcmp_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_vld     (req_vld),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .ordered     (ordered),
      .inv_en      (inv_en),
      .rsp_vld     (rsp_vld),
      .cc          (cc),
      .flg_snan    (flg_snan),
      .flg_inv_cmp (flg_inv_cmp)
   );

   localparam logic [63:0] PZ    = 64'h0000_0000_0000_0000;
   localparam logic [63:0] NZ    = 64'h8000_0000_0000_0000;
   localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] NONE  = 64'hBFF0_0000_0000_0000;
   localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
   localparam logic [63:0] NTWO  = 64'hC000_0000_0000_0000;
   localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] NQNAN = 64'hFFF8_0000_0000_0001;
   localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
   localparam logic [63:0] NSNAN = 64'hFFF4_0000_0000_0000;
   localparam logic [63:0] DEN   = 64'h0000_0000_0000_0001;
   localparam logic [63:0] DEN2  = 64'h0000_0000_0000_0002;
   localparam logic [63:0] NDEN  = 64'h8000_0000_0000_0001;
   localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;

   // behavioural reference state
   bit       m_vld  = 1'b0;
   bit [3:0] m_cc   = 4'b0010;
   bit       m_snan = 1'b0;
   bit       m_inv  = 1'b0;
   string    m_tag  = "R2";
   string    cur_tag = "R2";

   function automatic bit is_nan(input logic [63:0] x);
      return (x[62:52] == 11'h7FF) && (x[51:0] != 52'd0);
   endfunction

   task automatic ref_eval(input logic [63:0] a, input logic [63:0] b,
                           input bit ord, input bit ie);
      real ra, rb;
      bit  qa, qb, sa, sb;
      qa = is_nan(a) && a[51];
      qb = is_nan(b) && b[51];
      sa = is_nan(a) && !a[51];
      sb = is_nan(b) && !b[51];
      if (is_nan(a) || is_nan(b)) begin
         m_cc   = 4'b0001;
         m_snan = sa || sb;
         m_inv  = ord && (ie || qa || qb);
      end else begin
         ra = $bitstoreal(a);
         rb = $bitstoreal(b);
         if (ra < rb)      m_cc = 4'b1000;
         else if (ra > rb) m_cc = 4'b0100;
         else              m_cc = 4'b0010;
         m_snan = 1'b0;
         m_inv  = 1'b0;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_vld  = 1'b0;
         m_cc   = 4'b0010;
         m_snan = 1'b0;
         m_inv  = 1'b0;
         m_tag  = "R2";
      end else begin
         m_vld = req_vld;
         if (req_vld) begin
            ref_eval(opnd_a, opnd_b, ordered, inv_en);
            m_tag = cur_tag;
         end else begin
            m_tag = "R2";
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         total++;
         if ({rsp_vld, cc, flg_snan, flg_inv_cmp} !== {m_vld, m_cc, m_snan, m_inv}) begin
            bad++;
            $display("FAIL %s: got vld=%b cc=%b snan=%b inv=%b, want vld=%b cc=%b snan=%b inv=%b",
                     m_tag, rsp_vld, cc, flg_snan, flg_inv_cmp,
                     m_vld, m_cc, m_snan, m_inv);
         end
      end
   end

   task automatic cmp(input logic [63:0] a, input logic [63:0] b,
                      input bit ord, input bit ie, input string tag);
      @(negedge clk);
      opnd_a  = a;
      opnd_b  = b;
      ordered = ord;
      inv_en  = ie;
      req_vld = 1'b1;
      cur_tag = tag;
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic idle_noise(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         opnd_a  = {$urandom, $urandom};
         opnd_b  = QNAN;
         ordered = ~ordered;
         inv_en  = ~inv_en;
      end
   endtask

   function automatic logic [63:0] pick(input int unsigned s);
      case (s % 18)
         0:  return PZ;
         1:  return NZ;
         2:  return ONE;
         3:  return NONE;
         4:  return PINF;
         5:  return NINF;
         6:  return QNAN;
         7:  return SNAN;
         8:  return DEN;
         9:  return NDEN;
         10: return MAXF;
         11: return NSNAN;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);   // R2: reset values checked on these cycles

      // R3
      cmp(QNAN, ONE, 1'b0, 1'b0, "R3");
      cmp(ONE, NQNAN, 1'b0, 1'b0, "R3");
      // R4
      cmp(SNAN, ONE, 1'b0, 1'b0, "R4");
      cmp(ONE, NSNAN, 1'b1, 1'b1, "R4");
      // R5
      cmp(SNAN, SNAN, 1'b1, 1'b0, "R5");
      cmp(SNAN, QNAN, 1'b1, 1'b0, "R5");
      cmp(SNAN, ONE, 1'b1, 1'b1, "R5");
      cmp(QNAN, ONE, 1'b1, 1'b0, "R5");
      // R6
      cmp(QNAN, QNAN, 1'b0, 1'b1, "R6");
      cmp(SNAN, QNAN, 1'b0, 1'b1, "R6");
      cmp(ONE, TWO, 1'b1, 1'b1, "R6");
      // R7
      cmp(PZ, NZ, 1'b1, 1'b0, "R7");
      cmp(NZ, PZ, 1'b0, 1'b0, "R7");
      cmp(NZ, NZ, 1'b0, 1'b0, "R7");
      // R8
      cmp(NONE, PZ, 1'b0, 1'b0, "R8");
      cmp(PZ, NONE, 1'b0, 1'b0, "R8");
      cmp(NINF, DEN, 1'b0, 1'b0, "R8");
      cmp(NZ, DEN, 1'b0, 1'b0, "R8");
      // R9
      cmp(ONE, TWO, 1'b0, 1'b0, "R9");
      cmp(TWO, ONE, 1'b0, 1'b0, "R9");
      cmp(NONE, NTWO, 1'b0, 1'b0, "R9");
      cmp(PINF, MAXF, 1'b0, 1'b0, "R9");
      cmp(NZ, NONE, 1'b0, 1'b0, "R9");
      cmp(PZ, DEN, 1'b0, 1'b0, "R9");
      cmp(DEN, DEN2, 1'b0, 1'b0, "R9");
      // R10
      cmp(PINF, PINF, 1'b0, 1'b0, "R10");
      cmp(NINF, NINF, 1'b0, 1'b0, "R10");
      cmp(TWO, TWO, 1'b0, 1'b0, "R10");
      cmp(NDEN, NDEN, 1'b0, 1'b0, "R10");

      // R2: inputs change while idle, outputs must hold
      cmp(ONE, TWO, 1'b0, 1'b0, "R2");
      idle_noise(4);

      // R1: back-to-back requests, then mixed with gaps
      @(negedge clk);
      for (int i = 0; i < 40; i++) begin
         opnd_a  = pick($urandom);
         opnd_b  = pick($urandom);
         ordered = $urandom % 2;
         inv_en  = $urandom % 2;
         req_vld = 1'b1;
         cur_tag = "R1";
         @(negedge clk);
      end
      req_vld = 1'b0;
      for (int i = 0; i < 400; i++) begin
         cmp(pick($urandom), pick($urandom), 1'($urandom % 2), 1'($urandom % 2), "R1");
         if (i % 7 == 0) idle_noise(2);
      end
      repeat (3) @(negedge clk);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got no end of run, want end before timeout");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule